// File: doc/BRIEF.md
# Crystal Clock Stop Monitor with Automatic Failover

This block watches an external crystal clock from a free-running reference clock. It treats the crystal clock as data. The crystal clock passes through a synchronizer, and the block looks for rising edges. If no edge arrives within a set number of reference cycles, the crystal is reported as stopped. When detection and the stop interrupt are both enabled, the block switches the system clock selection to the internal oscillator on its own and raises a one-cycle interrupt request.

Software uses one 8-bit control/status register with the layout below. Bit 0 is detect enable. Bit 1 is stop-interrupt enable. Bit 2 is clock select (0 = crystal, 1 = internal oscillator). Bit 3 is the read-only stopped flag (1 = crystal stopped). Bits 7:4 always read 0.

A write takes effect only while the external unlock input is high. While the crystal is reported stopped, software cannot move the selection back to the crystal. Once edges return, the stopped flag clears by itself and software may then select the crystal again.

Top module: `osc_fail_guard`

## Requirements
- R1: After reset the register reads 8'h04, and both `sel_internal` and `lso_on` are 1.
- R2: A write with `wr_unlock` low leaves the register unchanged.
- R3: Bits 7:4 always read 0. Bit 3 cannot be changed by a software write.
- R4: With bit 0 set, bit 3 stays 0 while synchronized crystal rising edges keep arriving. Bit 3 becomes 1 once TIMEOUT (16) reference cycles pass with no rising edge.
- R5: With bit 0 clear, bit 3 reads 0 even if the crystal is stopped.
- R6: Bit 3 returns to 0 by itself once crystal rising edges are seen again.
- R7: If bits 1:0 are 11 when a stop is declared, the hardware sets bit 2 to 1.
- R8: If bits 1:0 are 01 when a stop is declared, bit 2 is not changed.
- R9: While bit 3 is 1, a write of 0 to bit 2 is ignored. Bits 1:0 remain writable during that time.
- R10: After bit 3 has cleared, a write of 0 to bit 2 selects the crystal.
- R11: `stop_irq` is a single-cycle pulse, raised once per 0-to-1 transition of bit 3. It is raised only when bits 1:0 are 11.
- R12: `lso_on` and `sel_internal` both equal bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| xtal_clk | input | 1 | Monitored crystal clock, sampled as data |
| wr_unlock | input | 1 | Write permission; writes are ignored while low |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| sel_internal | output | 1 | System clock select, 1 = internal oscillator |
| lso_on | output | 1 | Low-speed internal oscillator enable |
| stop_irq | output | 1 | One-cycle stop interrupt request |

## Verification
The bench uses the default parameters: TIMEOUT of 16 and a two-stage synchronizer. The crystal runs with a period of five reference cycles, well inside the timeout. Its stalls last 40 reference cycles, far beyond it. A sample taken eight cycles into a stall shows that the stop is not declared early. A sample taken after the stall shows that it is declared. Random register writes with random unlock settings cover write gating while the crystal runs. Directed stalls cover the 11, 01 and 00 settings of the enable bits.

// File: rtl/osc_guard_pkg.sv
package osc_guard_pkg;
  localparam int BIT_DET_EN = 0;
  localparam int BIT_IRQ_EN = 1;
  localparam int BIT_SEL    = 2;
  localparam int BIT_STOP   = 3;
  localparam logic [7:0] REG_RST_VAL = 8'h04;
endpackage

// File: rtl/xtal_edge_sync.sv
module xtal_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic xtal_clk,
  output logic rise
);
  localparam int MSB = SYNC_STAGES - 1;
  logic [MSB:0] chain;
  logic         last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain  <= '0;
      last_q <= 1'b0;
    end else begin
      chain  <= {chain[MSB-1:0], xtal_clk};
      last_q <= chain[MSB];
    end
  end

  assign rise = chain[MSB] & ~last_q;
endmodule

// File: rtl/stop_timer.sv
module stop_timer #(
  parameter int TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic rise,
  output logic stopped,
  output logic stop_evt
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT - 1);

  logic [CNT_W-1:0] cnt;
  logic             stopped_q;
  logic             evt_q;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      cnt       <= '0;
      stopped_q <= 1'b0;
      evt_q     <= 1'b0;
    end else begin
      evt_q <= 1'b0;
      if (rise) begin
        cnt       <= '0;
        stopped_q <= 1'b0;
      end else if (cnt == LIMIT) begin
        if (!stopped_q) evt_q <= 1'b1;
        stopped_q <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign stopped  = stopped_q & enable;
  assign stop_evt = evt_q & enable;
endmodule

// File: rtl/guard_ctl_reg.sv
module guard_ctl_reg
  import osc_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_unlock,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  input  logic       stopped,
  input  logic       stop_evt,
  output logic       det_en,
  output logic       irq_en,
  output logic       sel,
  output logic       irq
);
  logic wr_ok;
  logic armed_evt;

  assign wr_ok     = reg_we & wr_unlock;
  assign armed_evt = stop_evt & det_en & irq_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      det_en <= REG_RST_VAL[BIT_DET_EN];
      irq_en <= REG_RST_VAL[BIT_IRQ_EN];
      sel    <= REG_RST_VAL[BIT_SEL];
      irq    <= 1'b0;
    end else begin
      irq <= armed_evt;
      if (wr_ok) begin
        det_en <= reg_wdata[BIT_DET_EN];
        irq_en <= reg_wdata[BIT_IRQ_EN];
        if (reg_wdata[BIT_SEL]) sel <= 1'b1;
        else if (!stopped)      sel <= 1'b0;
      end
      if (armed_evt) sel <= 1'b1;
    end
  end
endmodule

// File: rtl/osc_fail_guard.sv
module osc_fail_guard
  import osc_guard_pkg::*;
#(
  parameter int TIMEOUT     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       xtal_clk,
  input  logic       wr_unlock,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       sel_internal,
  output logic       lso_on,
  output logic       stop_irq
);
  logic rise, stopped, stop_evt, det_en, irq_en, sel;

  xtal_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .xtal_clk(xtal_clk), .rise(rise)
  );

  stop_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk(clk), .rst(rst), .enable(det_en), .rise(rise),
    .stopped(stopped), .stop_evt(stop_evt)
  );

  guard_ctl_reg u_reg (
    .clk(clk), .rst(rst), .wr_unlock(wr_unlock), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .stopped(stopped), .stop_evt(stop_evt),
    .det_en(det_en), .irq_en(irq_en), .sel(sel), .irq(stop_irq)
  );

  always_comb begin
    reg_rdata             = '0;
    reg_rdata[BIT_DET_EN] = det_en;
    reg_rdata[BIT_IRQ_EN] = irq_en;
    reg_rdata[BIT_SEL]    = sel;
    reg_rdata[BIT_STOP]   = stopped;
  end

  assign sel_internal = sel;
  assign lso_on       = sel;
endmodule

// File: rtl/osc_fail_guard_chk.sv
module osc_fail_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_unlock,
  input logic       reg_we,
  input logic [7:0] reg_rdata,
  input logic       sel_internal,
  input logic       stop_irq
);
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    stop_irq |=> !stop_irq); // R11
  AST_IRQ_ARMED: assert property (@(posedge clk) disable iff (rst)
    stop_irq |-> reg_rdata[3]); // R11
  AST_NO_MON_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !reg_rdata[0] |-> !reg_rdata[3]); // R5
  AST_FORCE_INTERNAL: assert property (@(posedge clk) disable iff (rst)
    ($rose(reg_rdata[3]) && reg_rdata[1:0] == 2'b11) |=> sel_internal); // R7
  AST_HOLD_WHILE_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[3] && sel_internal) |=> sel_internal); // R9
  AST_WRITE_GATED: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && wr_unlock) |=> $stable(reg_rdata[1:0])); // R2
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[7:4] == 4'h0); // R3
endmodule

bind osc_fail_guard osc_fail_guard_chk u_chk (
  .clk(clk), .rst(rst), .wr_unlock(wr_unlock), .reg_we(reg_we),
  .reg_rdata(reg_rdata), .sel_internal(sel_internal), .stop_irq(stop_irq)
);

// File: tb/sim_osc_fail_guard.sv
`timescale 1ns/1ps
module sim_osc_fail_guard;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       xtal_clk = 1'b0;
  logic       xtal_run = 1'b1;
  logic       wr_unlock = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       sel_internal, lso_on, stop_irq;

  int n_chk = 0;
  int n_bad = 0;
  int irq_cnt = 0;
  logic [2:0] model;

  always #4 clk = ~clk;
  always #20 if (xtal_run) xtal_clk = ~xtal_clk;

  always @(posedge clk) if (!rst && stop_irq) irq_cnt <= irq_cnt + 1;

  osc_fail_guard u0 (
    .clk(clk), .rst(rst), .xtal_clk(xtal_clk), .wr_unlock(wr_unlock),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sel_internal(sel_internal), .lso_on(lso_on), .stop_irq(stop_irq)
  );

  function automatic logic [7:0] exp_reg(input logic [2:0] m, input logic stp);
    return {4'h0, stp, m};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic unl, input logic [7:0] d);
    @(negedge clk);
    wr_unlock = unl; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; wr_unlock = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(1);
    chk("R1 reset reg", reg_rdata, 8'h04);
    chk("R1 reset sel", sel_internal, 1);
    chk("R1 reset lso", lso_on, 1);
    chk("R11 reset irq", stop_irq, 0);

    wr(1'b0, 8'h03);
    chk("R2 locked write", reg_rdata, 8'h04);
    wr(1'b1, 8'hF8);
    chk("R3 reserved/bit3", reg_rdata, 8'h00);
    chk("R12 lso follows", lso_on, 0);

    model = 3'b000;
    void'($urandom(32'd1234));
    for (int i = 0; i < 150; i++) begin
      logic       u;
      logic [7:0] d;
      u = 1'($urandom);
      d = 8'($urandom);
      wr(u, d);
      if (u) model = d[2:0];
      chk(u ? "R3 random write" : "R2 random locked", reg_rdata, exp_reg(model, 1'b0));
      chk("R12 random sel/lso", {sel_internal, lso_on}, {model[2], model[2]});
    end

    // detection off: stalled crystal must not be flagged
    wr(1'b1, 8'h00);
    xtal_run = 1'b0;
    wait_cyc(40);
    chk("R5 monitor off", reg_rdata, 8'h00);
    xtal_run = 1'b1;
    wait_cyc(20);

    // armed 11, crystal selected
    wr(1'b1, 8'h03);
    irq_cnt = 0;
    xtal_run = 1'b0;
    wait_cyc(8);
    chk("R4 not early", reg_rdata[3], 0);
    wait_cyc(32);
    chk("R4 stop flagged", reg_rdata[3], 1);
    chk("R7 forced internal", sel_internal, 1);
    chk("R12 lso on", lso_on, 1);
    chk("R11 one irq", irq_cnt, 1);
    wr(1'b1, 8'h03);
    chk("R9 write 0 ignored", reg_rdata, 8'h0F);
    wr(1'b1, 8'h05);
    chk("R9 other bits writable", reg_rdata, 8'h0D);
    wr(1'b1, 8'h07);
    wait_cyc(5);
    chk("R11 no repeat irq", irq_cnt, 1);
    xtal_run = 1'b1;
    wait_cyc(20);
    chk("R6 flag clears", reg_rdata, 8'h07);
    wr(1'b1, 8'h03);
    chk("R10 back to crystal", reg_rdata, 8'h03);
    chk("R10 sel low", sel_internal, 0);

    // detect only, no interrupt enable
    wr(1'b1, 8'h01);
    irq_cnt = 0;
    xtal_run = 1'b0;
    wait_cyc(40);
    chk("R8 flag set", reg_rdata, 8'h09);
    chk("R8 not forced", sel_internal, 0);
    chk("R11 no irq unarmed", irq_cnt, 0);
    xtal_run = 1'b1;
    wait_cyc(20);
    chk("R6 clears again", reg_rdata, 8'h01);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule